// File: doc/BRIEF.md
# Serial ADC Device-Side Port

This block is the digital bus side of an eight-input, 12-bit successive-approximation converter. A bus master sends an active-low select, a serial clock and a data-in line. The block returns one serial data line that it drives only while the device is selected. The master's pins are oversampled in the system clock domain. Each pin passes through a two-flop synchroniser, and every serial-clock edge is found by comparing consecutive synchronised samples.

Within a select frame, serial-clock falling edges are counted in 16-edge slots. The count drives two phase outputs for an attached conversion engine. Tracking covers the first three clocks of a slot, and hold/convert covers the remaining thirteen. The engine returns its 12-bit result on a parallel port. At the hold boundary the block loads that result into a shift register and sends it out after four leading zeros. During each slot the block also collects a 3-bit channel address from the control word on the data-in line, and hands it to the engine for the following slot.

A frame may start with the serial clock high or low. When the clock is already low as select falls, the select edge counts as the first falling edge. A frame may hold several back-to-back slots. A frame that ends early is abandoned.

Top module: `sadc_port`

## Requirements
- R1: `dout_en_o` is 1 and `dout_o` is driven while the synchronised select is low. While select is high, `dout_en_o` is 0 and `dout_o` is released to high impedance.
- R2: While select is high, serial-clock and data-in activity does not change the phase outputs or `chan_o`, and it does not advance the edge count.
- R3: When select falls while the serial clock is high, both phase outputs stay 0 until the first serial-clock falling edge. That edge starts tracking.
- R4: When select falls while the serial clock is low, the select edge counts as falling edge 1 and tracking starts at once.
- R5: Falling edges 1, 2, 3 and 4 of a slot put a 0 on `dout_o`.
- R6: `result_i` is captured at falling edge 4. Falling edges 5 to 16 put its bits on `dout_o`, bit 11 first and bit 0 last.
- R7: `track_o` is 1 after falling edges 1 to 3 of a slot, and `hold_o` is 1 after falling edges 4 to 16. The two are never 1 together.
- R8: While select stays low, the falling edge after the 16th rising edge of a slot starts a new slot. Tracking restarts there, and hold restarts at that slot's fourth falling edge.
- R9: Data-in is sampled on serial-clock rising edges, most significant bit of the 16-bit word first. The channel address is word bits 13, 12 and 11 (rising edges 3, 4 and 5). Bit 13 becomes `chan_o[2]`.
- R10: The collected address appears on `chan_o` at the 16th rising edge of a slot. It stays fixed through the next slot's tracking. After reset `chan_o` is 0.
- R11: Raising select partway through a slot abandons it. `chan_o` keeps its previous value, and the next frame counts its edges from 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Active-low select from the bus master |
| sclk_i | input | 1 | Serial clock from the bus master |
| din_i | input | 1 | Serial control word from the master |
| result_i | input | 12 | Conversion result from the engine |
| dout_o | output | 1 | Serial data to the master, high impedance when deselected |
| dout_en_o | output | 1 | Output enable for `dout_o` |
| track_o | output | 1 | Tracking-phase indication to the engine |
| hold_o | output | 1 | Hold/convert-phase indication to the engine |
| chan_o | output | 3 | Input channel the engine should track |

## Verification
The assertions assume the bus pins are slow relative to the system clock. Every level on select and the serial clock must last long enough for the synchroniser to register it, so that each serial-clock edge is seen exactly once. They also assume data-in is settled before the rising edge that samples it, and that `result_i` is steady around the hold boundary. The bench holds every pin level for four system clocks. It changes data-in one system clock ahead of the serial-clock rise and keeps `result_i` constant for the whole slot, so the stimulus stays inside those assumptions.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end

    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sadc_slot_seq.sv
module sadc_slot_seq
  import sadc_pkg::*;
#(
  parameter  int SLOT_LEN  = 16,
  parameter  int TRACK_LEN = 3,
  localparam int CNT_W     = $clog2(SLOT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sclk_s,
  output logic             sel_now,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             sel_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output phase_e           phase
);

  logic cs_prev_q;
  logic sclk_prev_q;
  logic cs_fall;

  // Edge events and the next falling-edge count
  always_comb begin
    sel_now  = ~cs_n_s;
    cs_fall  = cs_prev_q & ~cs_n_s;
    // select falling while the clock is low counts as falling edge 1
    fall_evt = sel_now & (cs_fall ? ~sclk_s : (sclk_prev_q & ~sclk_s));
    rise_evt = sel_now & ~cs_fall & ~sclk_prev_q & sclk_s;
    cnt_d    = cnt_q;
    if (!sel_now) begin
      cnt_d = '0;
    end else if (fall_evt) begin
      if (cnt_q == CNT_W'(SLOT_LEN)) cnt_d = CNT_W'(1);
      else                           cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      sel_q       <= 1'b0;
      cnt_q       <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
      sel_q       <= sel_now;
      if (fall_evt || !sel_now) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (cnt_q == '0)                        phase = PH_IDLE;
    else if (cnt_q <= CNT_W'(TRACK_LEN))    phase = PH_TRACK;
    else                                    phase = PH_HOLD;
  end

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter  int DATA_W   = 12,
  parameter  int SLOT_LEN = 16,
  parameter  int ADDR_W   = 3,
  parameter  int ADDR_MSB = 13,
  parameter  int CNT_W    = 5,
  localparam int LEAD     = SLOT_LEN - DATA_W,
  localparam int ADDR_R0  = SLOT_LEN - ADDR_MSB,
  localparam int ADDR_R1  = ADDR_R0 + ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_now,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              din_s,
  input  logic [DATA_W-1:0] result_i,
  output logic              dout_q,
  output logic [ADDR_W-1:0] chan_q
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] pend_q, pend_d, chan_d;
  logic              dout_d;
  logic              sh_en, pend_en, chan_en;

  // Output side: leading zeros, then the result MSB first
  always_comb begin
    sh_d   = sh_q;
    dout_d = dout_q;
    sh_en  = 1'b0;
    if (!sel_now) begin
      dout_d = 1'b0;
    end else if (fall_evt) begin
      if (cnt_d == CNT_W'(LEAD)) begin
        sh_d   = result_i;
        sh_en  = 1'b1;
        dout_d = 1'b0;
      end else if (cnt_d > CNT_W'(LEAD)) begin
        dout_d = sh_q[DATA_W-1];
        sh_d   = {sh_q[DATA_W-2:0], 1'b0};
        sh_en  = 1'b1;
      end else begin
        dout_d = 1'b0;
      end
    end
  end

  // Input side: rising edge k carries word bit SLOT_LEN-k
  always_comb begin
    pend_d  = {pend_q[ADDR_W-2:0], din_s};
    pend_en = rise_evt && (cnt_q >= CNT_W'(ADDR_R0)) && (cnt_q <= CNT_W'(ADDR_R1));
    chan_d  = pend_q;
    chan_en = rise_evt && (cnt_q == CNT_W'(SLOT_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
      pend_q <= '0;
      chan_q <= '0;
    end else begin
      dout_q <= dout_d;
      if (sh_en)   sh_q   <= sh_d;
      if (pend_en) pend_q <= pend_d;
      if (chan_en) chan_q <= chan_d;
    end
  end

endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter  int DATA_W      = 12,
  parameter  int SLOT_LEN    = 16,
  parameter  int TRACK_LEN   = 3,
  parameter  int ADDR_W      = 3,
  parameter  int ADDR_MSB    = 13,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(SLOT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic              track_o,
  output logic              hold_o,
  output logic [ADDR_W-1:0] chan_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [2:0]       pins_s;
  logic             cs_n_s, sclk_s, din_s;
  logic             sel_now, fall_evt, rise_evt, sel_q, dout_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           phase;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sadc_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cs_n_i, sclk_i, din_i}),
    .q     (pins_s)
  );
  assign {cs_n_s, sclk_s, din_s} = pins_s;

  sadc_slot_seq #(
    .SLOT_LEN  (SLOT_LEN),
    .TRACK_LEN (TRACK_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n_s   (cs_n_s),
    .sclk_s   (sclk_s),
    .sel_now  (sel_now),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .sel_q    (sel_q),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .phase    (phase)
  );

  sadc_shifter #(
    .DATA_W   (DATA_W),
    .SLOT_LEN (SLOT_LEN),
    .ADDR_W   (ADDR_W),
    .ADDR_MSB (ADDR_MSB),
    .CNT_W    (CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_now  (sel_now),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .din_s    (din_s),
    .result_i (result_i),
    .dout_q   (dout_q),
    .chan_q   (chan_o)
  );

  assign dout_en_o = sel_q;
  assign dout_o    = sel_q ? dout_q : 1'bz;
  assign track_o   = (phase == PH_TRACK);
  assign hold_o    = (phase == PH_HOLD);

endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dout,
  input logic              dout_en,
  input logic              track,
  input logic              hold,
  input logic [ADDR_W-1:0] chan
);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold)); // R7

  AST_HOLD_FROM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(track)); // R7

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (!track && !hold)); // R2

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && track) |-> (dout == 1'b0)); // R5

  AST_CHAN_STEADY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (track && $past(track)) |-> $stable(chan)); // R10

  AST_CHAN_KEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> $stable(chan)); // R11

endmodule

bind sadc_port sadc_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dout    (dout_o),
  .dout_en (dout_en_o),
  .track   (track_o),
  .hold    (hold_o),
  .chan    (chan_o)
);

// File: tb/sim_sadc_port.sv
module sim_sadc_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] res = 12'h000;
  wire         dout;
  logic        den, trk, hld;
  logic [2:0]  chan;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sadc_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n),
    .sclk_i    (sclk),
    .din_i     (din),
    .result_i  (res),
    .dout_o    (dout),
    .dout_en_o (den),
    .track_o   (trk),
    .hold_o    (hld),
    .chan_o    (chan)
  );

  // {low_entry, result, control word}
  localparam logic [28:0] VEC [6] = '{
    {1'b0, 12'hA5C, 16'h2800},
    {1'b1, 12'hFFF, 16'h1000},
    {1'b0, 12'h001, 16'hFFFF},
    {1'b1, 12'h800, 16'h0000},
    {1'b0, 12'h3C3, 16'h0800},
    {1'b1, 12'h555, 16'hC7FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // One 16-clock slot; ec >= 0 checks the channel seen during tracking
  task automatic run_slot(input logic [11:0] r, input logic [15:0] w,
                          input bit low_entry, input bit fresh, input int ec);
    logic e;
    res = r;
    if (fresh) begin
      if (low_entry) begin
        sclk = 1'b0; settle();
      end else begin
        sclk = 1'b1; settle();
        cs_n = 1'b0; settle();
        chk(trk == 0 && hld == 0, "R3 idle before first fall", {trk, hld}, 0);
      end
    end
    for (int k = 1; k <= 16; k++) begin
      if (k == 1 && fresh && low_entry) cs_n = 1'b0;
      else                              sclk = 1'b0;
      settle();
      if (k == 1) begin
        chk(den == 1'b1, "R1 driven while selected", den, 1);
        if (fresh && low_entry)  chk(trk == 1'b1, "R4 select edge is fall 1", trk, 1);
        else if (fresh)          chk(trk == 1'b1, "R3 first fall starts track", trk, 1);
        else                     chk(trk == 1'b1, "R8 next slot tracks", trk, 1);
      end
      if (k <= 4) e = 1'b0;
      else        e = r[16-k];
      if (k <= 4) chk(dout === e, "R5 leading zero", dout, e);
      else        chk(dout === e, "R6 result bit", dout, e);
      if (fresh) chk(trk == (k <= 3) && hld == (k >= 4), "R7 phase",
                     {trk, hld}, {(k <= 3), (k >= 4)});
      else       chk(trk == (k <= 3) && hld == (k >= 4), "R8 continuous phase",
                     {trk, hld}, {(k <= 3), (k >= 4)});
      if (ec >= 0 && k == 2) chk(chan == ec[2:0], "R10 channel during track", chan, ec);
      din = w[16-k];
      @(negedge clk);
      sclk = 1'b1;
      settle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] keep;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk(den == 1'b0, "R1 released after reset", den, 0);
    chk(trk == 0 && hld == 0, "R7 no phase after reset", {trk, hld}, 0);
    chk(chan == 3'd0, "R10 channel reset value", chan, 0);

    // Vector table: one slot per frame
    for (int i = 0; i < 6; i++) begin
      run_slot(VEC[i][27:16], VEC[i][15:0], VEC[i][28], 1'b1, -1);
      cs_n = 1'b1;
      settle();
      chk(den == 1'b0, "R1 released after frame", den, 0);
      chk(chan == VEC[i][13:11], "R9 channel from word", chan, VEC[i][13:11]);
    end

    // Serial clock ignored while deselected
    keep = chan;
    for (int t = 0; t < 8; t++) begin
      sclk = ~sclk;
      din  = ~din;
      settle();
    end
    chk(den == 1'b0, "R2 no drive while deselected", den, 0);
    chk(trk == 0 && hld == 0, "R2 no phase while deselected", {trk, hld}, 0);
    chk(chan == keep, "R2 channel unchanged", chan, keep);
    run_slot(12'h6B1, 16'h3000, 1'b0, 1'b1, -1);
    cs_n = 1'b1; settle();
    chk(chan == 3'd6, "R2 count not advanced", chan, 6);

    // Continuous operation: two slots in one frame
    run_slot(12'h9A7, 16'h2000, 1'b1, 1'b1, -1);
    run_slot(12'h35E, 16'h0800, 1'b0, 1'b0, 4);
    cs_n = 1'b1; settle();
    chk(chan == 3'd1, "R8 second slot channel", chan, 1);

    // Abort partway through a slot
    sclk = 1'b1; settle();
    cs_n = 1'b0; settle();
    for (int k = 1; k <= 10; k++) begin
      sclk = 1'b0; settle();
      din = k[0];
      @(negedge clk);
      sclk = 1'b1; settle();
    end
    cs_n = 1'b1; settle();
    chk(chan == 3'd1, "R11 abort keeps channel", chan, 1);
    chk(trk == 0 && hld == 0, "R11 abort clears phase", {trk, hld}, 0);
    run_slot(12'hC3A, 16'h1800, 1'b0, 1'b1, -1);
    cs_n = 1'b1; settle();
    chk(chan == 3'd3, "R11 fresh frame after abort", chan, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule